// File: doc/BRIEF.md
# Multi-mode 8-bit PWM timer

An 8-bit counter that advances once per count-enable tick and drives two waveform outputs, A and B, from compare matches. A 3-bit mode value sets four things: the counting sequence (up only, or up then down), where the TOP value comes from (fixed at all ones, or compare A), when newly written compare values take effect, and when the overflow flag is raised. Six codes are usable: free-running, clear-on-compare, fast PWM at two TOP sources, and phase-correct PWM at two TOP sources. Codes 4 and 6 freeze the block.

Software reaches the block through one write port. Select 0 writes the control word. Selects 1 and 2 write compare A and compare B. Select 3 clears flags by writing a 1 to the matching bit. Each output has a 2-bit action code that says how matches and period ends move the pin. The output-enable pin for a channel drops when its action code is 00.

Top module: `pwm_tmr`

## Requirements
- R1: After reset the counter is 0 and counts upward. The mode is 0, both action codes are 00, both compare values are 0, both waveform outputs are low, both output enables are low and all three flags are clear.
- R2: Mode 0 is free-running. The mode is written with select 0 into data[2:0]. In this mode the counter adds 1 per tick and wraps from 0xFF to 0x00. A tick taken while the count is 0xFF sets the overflow flag. When tick_i is low the counter does not move.
- R3: Mode 2 is clear-on-compare. A tick at a count equal to the active compare A value loads 0. Any other tick adds 1, so a count above compare A runs on to 0xFF and wraps. The overflow flag is set only by a tick taken at 0xFF.
- R4: Modes 3 and 7 are fast PWM, counting up only. TOP is 0xFF in mode 3 and the active compare A value in mode 7. A tick at TOP loads 0; this wrap tick is the period end. The wrap tick sets the overflow flag and copies both pending compare values into the active ones.
- R5: Modes 1 and 5 are phase-correct. TOP is 0xFF in mode 1 and the active compare A value in mode 5. The count runs 0 up to TOP and back down to 0, and each of TOP and 0 is held for exactly one tick. The tick taken at TOP copies the pending compare values into the active ones. The tick that leaves 0 after counting down sets the overflow flag.
- R6: Compare A is written with select 1 and compare B with select 2. In modes 0 and 2 (and 4 and 6) a write becomes active on the same clock edge. In modes 1, 3, 5 and 7 a write stays pending until the load tick of R4 or R5.
- R7: A tick at a count equal to a channel's active compare value sets that channel's compare flag. This applies in every mode except 4 and 6. Flags stay set until a select-3 write with a 1 in the flag's bit: bit 0 is overflow, bit 1 is compare A, bit 2 is compare B. A set event in the same cycle as a clear wins.
- R8: Action codes are written with select 0: channel A in data[4:3], channel B in data[6:5]. In modes 0 and 2 a match tick does the following: code 01 toggles the output, 10 drives it low, 11 drives it high.
- R9: In fast PWM, code 10 drives the output low on a match and high on the wrap tick. Code 11 does the reverse. When a match and the wrap fall on the same tick (compare equal to TOP), the wrap action wins. Code 01 leaves the output unchanged.
- R10: In phase-correct PWM, code 10 drives the output low on a match during an upward step and high on a match during a downward step. Code 11 does the reverse. The step taken at TOP is downward and the step taken at 0 is upward. So a compare equal to TOP takes the downward action at TOP.
- R11: A channel's output-enable is high exactly when its action code is not 00. While the code is 00 its waveform output does not change.
- R12: In modes 4 and 6, ticks change neither the counter, nor the waveform outputs, nor the flags. Register writes and flag clears still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 control, 1 compare A, 2 compare B, 3 flag clear |
| wr_data_i | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current count |
| wave_a_o | output | 1 | Waveform A |
| wave_b_o | output | 1 | Waveform B |
| wave_a_oe_o | output | 1 | Waveform A drives its pin |
| wave_b_oe_o | output | 1 | Waveform B drives its pin |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_a_flag_o | output | 1 | Compare A flag |
| cmp_b_flag_o | output | 1 | Compare B flag |

## Verification
The assertions check the following on every cycle:
- the counter holds still without a tick;
- it increments in free-running mode and clears at compare A in clear-on-compare mode;
- it steps by exactly one inside the phase-correct range;
- it freezes, along with waveform A, in the reserved codes;
- the overflow flag stays set until a clear write;
- a disconnected channel holds its output.

Some behaviour shows only over whole periods, and only the bench scenarios can show it. This covers the deferred compare loads, the corner cases where a compare equals TOP, the action taken by step direction at both ends of the phase-correct triangle, and switching between modes mid-count. The bench tracks all of these by stepping an arithmetic model from the requirements alongside the block.

// File: rtl/pwm_tmr_pkg.sv
`timescale 1ns/1ps
package pwm_tmr_pkg;
  typedef enum logic [2:0] {
    MD_FREE = 3'd0, MD_PC_FULL = 3'd1, MD_CTC = 3'd2, MD_FAST_FULL = 3'd3,
    MD_RSV4 = 3'd4, MD_PC_CMP = 3'd5, MD_RSV6 = 3'd6, MD_FAST_CMP = 3'd7
  } mode_e;

  typedef enum logic [2:0] {K_FREE, K_CTC, K_FAST, K_PC, K_HOLD} kind_e;

  typedef enum logic [1:0] {OM_OFF = 2'b00, OM_ALT = 2'b01, OM_LO = 2'b10, OM_HI = 2'b11} om_e;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_CMP_A = 2'd1;
  localparam logic [1:0] SEL_FLAG  = 2'd3;

  function automatic kind_e mode_kind(mode_e m);
    case (m)
      MD_FREE:                  return K_FREE;
      MD_CTC:                   return K_CTC;
      MD_FAST_FULL, MD_FAST_CMP: return K_FAST;
      MD_PC_FULL, MD_PC_CMP:    return K_PC;
      default:                  return K_HOLD;
    endcase
  endfunction

  function automatic logic top_from_cmp(mode_e m);
    return (m == MD_CTC) || (m == MD_PC_CMP) || (m == MD_FAST_CMP);
  endfunction

  function automatic logic cmp_immediate(kind_e k);
    return (k == K_FREE) || (k == K_CTC) || (k == K_HOLD);
  endfunction
endpackage

// File: rtl/pwm_tmr_cnt.sv
`timescale 1ns/1ps
module pwm_tmr_cnt
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  kind_e            kind_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_ev_o,
  output logic             load_ev_o,
  output logic             wrap_ev_o,
  output logic             step_dn_o
);
  localparam logic [CNT_W-1:0] MAX  = '1;
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dn_q, dn_d;

  always_comb begin
    cnt_d     = cnt_q;
    dn_d      = dn_q;
    ovf_ev_o  = 1'b0;
    load_ev_o = 1'b0;
    wrap_ev_o = 1'b0;
    step_dn_o = 1'b0;
    if (run_i) begin
      unique case (kind_i)
        K_FREE: begin
          cnt_d    = cnt_q + ONE;
          dn_d     = 1'b0;
          ovf_ev_o = (cnt_q == MAX);
        end
        K_CTC: begin
          cnt_d    = (cnt_q == top_i) ? ZERO : cnt_q + ONE;
          dn_d     = 1'b0;
          ovf_ev_o = (cnt_q == MAX);
        end
        K_FAST: begin
          wrap_ev_o = (cnt_q == top_i);
          cnt_d     = wrap_ev_o ? ZERO : cnt_q + ONE;
          dn_d      = 1'b0;
          ovf_ev_o  = wrap_ev_o;
          load_ev_o = wrap_ev_o;
        end
        K_PC: begin
          if (top_i == ZERO) begin
            cnt_d     = ZERO;
            dn_d      = 1'b0;
            load_ev_o = 1'b1;
          end else if (!dn_q) begin
            if (cnt_q >= top_i) begin
              // turn at TOP: this step is downward
              dn_d      = 1'b1;
              cnt_d     = cnt_q - ONE;
              load_ev_o = 1'b1;
              step_dn_o = 1'b1;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else if (cnt_q == ZERO) begin
            dn_d     = 1'b0;
            cnt_d    = ONE;
            ovf_ev_o = 1'b1;
          end else begin
            cnt_d     = cnt_q - ONE;
            step_dn_o = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ZERO;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_tmr_ocr.sv
`timescale 1ns/1ps
module pwm_tmr_ocr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             imm_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i) pend_q <= data_i;
      if (imm_i)       act_q <= wr_i ? data_i : pend_q;
      else if (load_i) act_q <= pend_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pwm_tmr_wave.sv
`timescale 1ns/1ps
module pwm_tmr_wave
  import pwm_tmr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  kind_e kind_i,
  input  om_e   om_i,
  input  logic  match_i,
  input  logic  wrap_i,
  input  logic  step_dn_i,
  output logic  wave_o,
  output logic  oe_o
);
  logic w_q, w_d;

  always_comb begin
    w_d = w_q;
    if (run_i && (om_i != OM_OFF)) begin
      unique case (kind_i)
        K_FREE, K_CTC: begin
          if (match_i) begin
            unique case (om_i)
              OM_ALT:  w_d = !w_q;
              OM_LO:   w_d = 1'b0;
              OM_HI:   w_d = 1'b1;
              default: ;
            endcase
          end
        end
        K_FAST: begin
          // period end outranks a match on the same tick
          if (wrap_i) begin
            if (om_i == OM_LO)      w_d = 1'b1;
            else if (om_i == OM_HI) w_d = 1'b0;
          end else if (match_i) begin
            if (om_i == OM_LO)      w_d = 1'b0;
            else if (om_i == OM_HI) w_d = 1'b1;
          end
        end
        K_PC: begin
          if (match_i) begin
            if (om_i == OM_LO)      w_d = step_dn_i;
            else if (om_i == OM_HI) w_d = !step_dn_i;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) w_q <= 1'b0;
    else         w_q <= w_d;
  end

  assign wave_o = w_q;
  assign oe_o   = (om_i != OM_OFF);
endmodule

// File: rtl/pwm_tmr.sv
`timescale 1ns/1ps
module pwm_tmr
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wave_a_o,
  output logic             wave_b_o,
  output logic             wave_a_oe_o,
  output logic             wave_b_oe_o,
  output logic             ovf_flag_o,
  output logic             cmp_a_flag_o,
  output logic             cmp_b_flag_o
);
  localparam int unsigned NCH   = 2;
  localparam int unsigned OM_LS = 3;

  mode_e            mode_q;
  om_e              om_q [NCH];
  logic [CNT_W-1:0] act   [NCH];
  logic [NCH-1:0]   wave, oe, match, cmp_wr;
  kind_e            kind;
  logic             run, imm, ovf_ev, load_ev, wrap_ev, step_dn, wr_ctrl;
  logic [CNT_W-1:0] cnt, top;
  logic [NCH:0]     flag_clr;
  logic             ovf_q;
  logic [NCH-1:0]   cf_q;

  assign kind     = mode_kind(mode_q);
  assign run      = tick_i && (kind != K_HOLD);
  assign imm      = cmp_immediate(kind);
  assign top      = top_from_cmp(mode_q) ? act[0] : '1;
  assign wr_ctrl  = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign flag_clr = (wr_en_i && (wr_sel_i == SEL_FLAG)) ? wr_data_i[NCH:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_FREE;
      for (int i = 0; i < NCH; i++) om_q[i] <= OM_OFF;
    end else if (wr_ctrl) begin
      mode_q <= mode_e'(wr_data_i[2:0]);
      for (int i = 0; i < NCH; i++) om_q[i] <= om_e'(wr_data_i[OM_LS+2*i +: 2]);
    end
  end

  pwm_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .kind_i    (kind),
    .top_i     (top),
    .cnt_o     (cnt),
    .ovf_ev_o  (ovf_ev),
    .load_ev_o (load_ev),
    .wrap_ev_o (wrap_ev),
    .step_dn_o (step_dn)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign cmp_wr[g] = wr_en_i && (wr_sel_i == SEL_CMP_A + 2'(g));
    assign match[g]  = (cnt == act[g]);

    pwm_tmr_ocr #(.CNT_W(CNT_W)) u_ocr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (cmp_wr[g]),
      .data_i (wr_data_i),
      .imm_i  (imm),
      .load_i (load_ev),
      .act_o  (act[g])
    );

    pwm_tmr_wave u_wave (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .kind_i    (kind),
      .om_i      (om_q[g]),
      .match_i   (match[g]),
      .wrap_i    (wrap_ev),
      .step_dn_i (step_dn),
      .wave_o    (wave[g]),
      .oe_o      (oe[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      cf_q  <= '0;
    end else begin
      ovf_q <= (ovf_q && !flag_clr[0]) || ovf_ev;
      for (int i = 0; i < NCH; i++)
        cf_q[i] <= (cf_q[i] && !flag_clr[i+1]) || (run && match[i]);
    end
  end

  assign cnt_o        = cnt;
  assign wave_a_o     = wave[0];
  assign wave_b_o     = wave[1];
  assign wave_a_oe_o  = oe[0];
  assign wave_b_oe_o  = oe[1];
  assign ovf_flag_o   = ovf_q;
  assign cmp_a_flag_o = cf_q[0];
  assign cmp_b_flag_o = cf_q[1];
endmodule

// File: rtl/pwm_tmr_chk.sv
`timescale 1ns/1ps
module pwm_tmr_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             clr_ovf_i,
  input logic [2:0]       mode_i,
  input logic [1:0]       om_a_i,
  input logic [CNT_W-1:0] top_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             wave_a_o,
  input logic             ovf_flag_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));

  a_r2_free_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 3'd0) |=> (cnt_o == $past(cnt_o) + ONE));

  a_r3_ctc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 3'd2 && cnt_o == top_i) |=> (cnt_o == '0));

  a_r5_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (mode_i == 3'd1 || mode_i == 3'd5) && top_i != '0 && cnt_o <= top_i)
    |=> (cnt_o == $past(cnt_o) + ONE || cnt_o == $past(cnt_o) - ONE));

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !clr_ovf_i) |=> ovf_flag_o);

  a_r11_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (om_a_i == 2'b00) |=> $stable(wave_a_o));

  a_r12_rsvd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (mode_i == 3'd4 || mode_i == 3'd6)) |=> ($stable(cnt_o) && $stable(wave_a_o)));
endmodule

bind pwm_tmr pwm_tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .clr_ovf_i  (flag_clr[0]),
  .mode_i     (mode_q),
  .om_a_i     (om_q[0]),
  .top_i      (top),
  .cnt_o      (cnt_o),
  .wave_a_o   (wave_a_o),
  .ovf_flag_o (ovf_flag_o)
);

// File: tb/tb_pwm_tmr.sv
`timescale 1ns/1ps
module tb_pwm_tmr;
  localparam int  W     = 8;
  localparam time CLK_P = 4ns;

  logic         clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt;
  logic         wa, wb, oea, oeb, fo, fa, fb;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model state
  int m_cnt = 0, m_dn = 0, m_mode = 0, m_fo = 0, last_mode = 0;
  int m_om[2], m_pend[2], m_act[2], m_w[2], m_fc[2];

  always #(CLK_P/2) clk = ~clk;

  pwm_tmr #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .cnt_o(cnt), .wave_a_o(wa), .wave_b_o(wb),
    .wave_a_oe_o(oea), .wave_b_oe_o(oeb), .ovf_flag_o(fo), .cmp_a_flag_o(fa), .cmp_b_flag_o(fb)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int kind_of(int m);
    case (m)
      0: return 0;
      2: return 1;
      3, 7: return 2;
      1, 5: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic model(bit t, bit w, int s, int d);
    int k, top, nc, nd, ovf, load, wrap, sdn, run, imm, mt, om, clr;
    k    = kind_of(m_mode);
    top  = (m_mode == 2 || m_mode == 5 || m_mode == 7) ? m_act[0] : 255;
    run  = (t && k != 4);
    imm  = (k == 0 || k == 1 || k == 4);
    nc = m_cnt; nd = m_dn; ovf = 0; load = 0; wrap = 0; sdn = 0;
    last_mode = m_mode;
    if (run) begin
      case (k)
        0: begin nc = (m_cnt + 1) % 256; nd = 0; ovf = (m_cnt == 255); end
        1: begin nc = (m_cnt == top) ? 0 : (m_cnt + 1) % 256; nd = 0; ovf = (m_cnt == 255); end
        2: begin wrap = (m_cnt == top); nc = wrap ? 0 : (m_cnt + 1) % 256; nd = 0; ovf = wrap; load = wrap; end
        default: begin
          if (top == 0) begin nc = 0; nd = 0; load = 1; end
          else if (m_dn == 0) begin
            if (m_cnt >= top) begin nd = 1; nc = m_cnt - 1; load = 1; sdn = 1; end
            else nc = m_cnt + 1;
          end else if (m_cnt == 0) begin nd = 0; nc = 1; ovf = 1; end
          else begin nc = m_cnt - 1; sdn = 1; end
        end
      endcase
    end
    clr = (w && s == 3) ? d : 0;
    m_fo = ((m_fo != 0) && ((clr & 1) == 0)) || (ovf != 0);
    for (int i = 0; i < 2; i++) begin
      mt = (m_cnt == m_act[i]);
      om = m_om[i];
      if (run && om != 0) begin
        case (k)
          0, 1: if (mt) m_w[i] = (om == 1) ? 1 - m_w[i] : (om == 3);
          2: begin
            if (wrap) begin if (om == 2) m_w[i] = 1; else if (om == 3) m_w[i] = 0; end
            else if (mt) begin if (om == 2) m_w[i] = 0; else if (om == 3) m_w[i] = 1; end
          end
          default: if (mt) begin if (om == 2) m_w[i] = sdn; else if (om == 3) m_w[i] = 1 - sdn; end
        endcase
      end
      m_fc[i] = ((m_fc[i] != 0) && (((clr >> (i + 1)) & 1) == 0)) || (run && mt);
      if (imm) m_act[i] = (w && s == i + 1) ? d : m_pend[i];
      else if (run && load) m_act[i] = m_pend[i];
      if (w && s == i + 1) m_pend[i] = d;
    end
    if (w && s == 0) begin
      m_mode = d & 7; m_om[0] = (d >> 3) & 3; m_om[1] = (d >> 5) & 3;
    end
    m_cnt = nc; m_dn = nd;
  endtask

  task automatic compare_all();
    string tc, tw;
    case (last_mode)
      0: begin tc = "R2"; tw = "R8"; end
      2: begin tc = "R3/R6"; tw = "R8"; end
      3: begin tc = "R4"; tw = "R9"; end
      7: begin tc = "R4/R6"; tw = "R9"; end
      1: begin tc = "R5"; tw = "R10"; end
      5: begin tc = "R5/R6"; tw = "R10"; end
      default: begin tc = "R12"; tw = "R12"; end
    endcase
    chk(tc, "count", cnt, m_cnt);
    chk(tw, "wave A", wa, m_w[0]);
    chk(tw, "wave B", wb, m_w[1]);
    chk("R11", "oe A", oea, m_om[0] != 0);
    chk("R11", "oe B", oeb, m_om[1] != 0);
    chk("R7", "ovf flag", fo, m_fo);
    chk("R7", "cmp A flag", fa, m_fc[0]);
    chk("R7", "cmp B flag", fb, m_fc[1]);
  endtask

  task automatic cyc(bit t, bit w = 0, int s = 0, int d = 0);
    @(negedge clk);
    tick = t; wr_en = w; wr_sel = s[1:0]; wr_data = d[W-1:0];
    @(posedge clk);
    model(t, w, s, d);
    #1;
    compare_all();
  endtask

  task automatic wr(int s, int d);
    cyc(1'b0, 1'b1, s, d);
  endtask

  task automatic ctrl(int mode, int oma, int omb);
    wr(0, mode | (oma << 3) | (omb << 5));
  endtask

  task automatic run(int n, int gap = 0);
    for (int k = 0; k < n; k++) begin
      bit t;
      t = (gap == 0) ? 1'b1 : ((k % gap) != 0);
      if (k % 97 == 50) cyc(t, 1'b1, 3, k % 8);
      else cyc(t);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_om[i] = 0; m_pend[i] = 0; m_act[i] = 0; m_w[i] = 0; m_fc[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "count", cnt, 0);
    chk("R1", "wave A", wa, 0);
    chk("R1", "wave B", wb, 0);
    chk("R1", "oe", {oea, oeb}, 0);
    chk("R1", "flags", {fo, fa, fb}, 0);
    rst_ni = 1'b1;
    cyc(1'b0);
    chk("R1", "count after release", cnt, 0);

    // R2 R8: free-running, toggle / set, with tick gaps
    ctrl(0, 1, 3); wr(1, 64); wr(2, 128);
    run(600, 7);
    ctrl(0, 2, 1); run(300);

    // R3 R6: clear-on-compare, then compare lowered below count
    ctrl(2, 1, 2); wr(1, 20); wr(2, 10);
    run(100); run(13); wr(1, 5); run(400);

    // R4 R9: fast, full TOP, B equal to TOP, buffered write
    ctrl(3, 2, 2); wr(1, 100); wr(2, 255);
    run(600); wr(1, 30); run(600);
    ctrl(3, 3, 3); run(300);
    ctrl(3, 1, 1); run(50);

    // R4 R6 R9: fast, TOP from compare A
    ctrl(7, 2, 3); wr(1, 50); wr(2, 20);
    run(200); wr(2, 50); run(200); wr(1, 80); run(200, 5);

    // R5 R10: phase-correct, full TOP, B at TOP and at 0
    ctrl(1, 2, 2); wr(1, 48); wr(2, 255);
    run(1100); ctrl(1, 3, 3); wr(2, 0); run(1100);

    // R5 R6 R10: phase-correct, TOP from compare A
    ctrl(5, 2, 3); wr(1, 40); wr(2, 10);
    run(300); wr(2, 40); run(300); wr(1, 60); run(300, 9);

    // R12: reserved codes freeze, writes still land
    ctrl(4, 2, 2); run(50); wr(3, 7); wr(1, 33);
    ctrl(6, 1, 1); run(50);

    // R11: disconnected outputs hold
    ctrl(0, 0, 0); run(300);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule